// File: doc/BRIEF.md
# Leap-Forward Pseudo-Random Bit Generator

This block is a shift-register pseudo-random generator in Fibonacci form. The feedback taps are chosen by a mask parameter, so one module covers any register length and polynomial. On every clock edge it moves the register forward by several single-bit steps rather than one. This lets it hand out a word of several random bits per cycle. Adjacent bits of such a word would be strongly correlated if the register advanced only one step per clock.

The multi-step update is built as a chain of single-step updates in combinational logic. Each link of the chain works on the result of the link before it. The new bit is the inverted parity of the tapped state bits. Because of this inversion the all-zero state is a legal member of the sequence, which lets the asynchronous active-low reset clear the register to zero. The all-ones state becomes the stuck state instead. The random word is read from the most significant end of the register.

Top module: `lfsr_leap`

## Requirements
- R1: While `rst_n` is low the register is all zeros and `rnd` is 0. The clear takes effect without waiting for a clock edge.
- R2: A single step computes the parity of (state AND `TAPS`), inverts it, shifts the state left by one and puts the inverted parity into bit 0. With `BITS`=1 each clock performs exactly one such step.
- R3: Each clock performs `BITS` single steps in sequence, each step taking the result of the previous one. With N=4, `TAPS`=4'h9 and `BITS`=2, `rnd` reads 2'b00 after the first clock out of reset and 2'b10 after the second.
- R4: `rnd` equals state bits N-1 down to N-`BITS`. With `BITS`=N it shows the whole state.
- R5: From reset, a register whose mask describes a maximal-length polynomial never holds all ones. With N=4, `TAPS`=4'h9 and `BITS`=4, the state first returns to zero after exactly 15 clocks.
- R6: If reset is applied in the middle of a run, the sequence that follows its release is the same one that follows a power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears the state to zero |
| rnd | output | BITS | Random word, taken from the top BITS bits of the state |

## Verification
The generator is built four times, with the leap lengths 1, 2, 3 and 4 and with register lengths of 4 and 8 bits. Each copy is compared cycle by cycle against a step-by-step bench model. The one-step copy separates errors in the basic shift and feedback from errors in the chaining. The full-width copy shows the entire state, so a skipped or doubled step, a stuck all-ones value and a wrong period can all be seen. Reset is asserted at random points in a run and released after a random delay. This shows whether the clear is immediate and whether the sequence restarts from zero, rather than continuing from the state held before the reset.

// File: rtl/lfsr_leap.sv
`timescale 1ns/1ps
module lfsr_leap #(
  parameter int N = 4,
  parameter logic [N-1:0] TAPS = 4'h9,
  parameter int BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [BITS-1:0] rnd
);

  // legal leap lengths are 1..N on a register of at least two bits
  generate
    if (BITS < 1 || BITS > N || N < 2) begin : g_bad_cfg
      $error("lfsr_leap: BITS must lie in 1..N and N must be at least 2");
    end
  endgenerate

  logic [N-1:0] state, state_nx;

  function automatic logic [N-1:0] one_step(input logic [N-1:0] s);
    one_step = {s[N-2:0], ~^(s & TAPS)};
  endfunction

  always_comb begin
    state_nx = state;
    for (int i = 0; i < BITS; i++) state_nx = one_step(state_nx);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= '0;
    else        state <= state_nx;

  assign rnd = state[N-1 -: BITS];

  always @(negedge clk)
    if (!rst_n) AST_RST_CLEAR: assert (state == '0 && rnd == '0); // R1

  AST_RELEASE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> $past(state) == '0); // R6

  AST_NEVER_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    state != '1); // R5

  generate
    if (BITS < N) begin : g_shift_chk
      AST_LEAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state[N-1:BITS] == $past(state[N-1-BITS:0])); // R3
    end
  endgenerate

endmodule

// File: tb/tb_lfsr_leap.sv
`timescale 1ns/1ps
module tb_lfsr_leap;
  logic clk = 0, rst_n = 0;
  logic [1:0] r2;
  logic [0:0] r1;
  logic [3:0] r4;
  logic [2:0] r8;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m1, m2, m4, m8;

  always #2.5 clk = ~clk;

  lfsr_leap #(.N(4), .TAPS(4'h9), .BITS(2)) dut (.clk(clk), .rst_n(rst_n), .rnd(r2));
  lfsr_leap #(.N(4), .TAPS(4'h9), .BITS(1)) u1  (.clk(clk), .rst_n(rst_n), .rnd(r1));
  lfsr_leap #(.N(4), .TAPS(4'h9), .BITS(4)) u4  (.clk(clk), .rst_n(rst_n), .rnd(r4));
  lfsr_leap #(.N(8), .TAPS(8'hB8), .BITS(3)) u8 (.clk(clk), .rst_n(rst_n), .rnd(r8));

  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] mask,
                                        input int n, input int bits);
    logic [31:0] lim = (32'd1 << n) - 32'd1;
    for (int i = 0; i < bits; i++) s = ((s << 1) | {31'd0, ~(^(s & mask))}) & lim;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({"R2 ", tag}, {31'd0, r1}, m1 >> 3);
    check({"R3 ", tag}, {30'd0, r2}, m2 >> 2);
    check({"R4 ", tag}, {28'd0, r4}, m4);
    check({"R4 n8 ", tag}, {29'd0, r8}, m8 >> 5);
    check({"R5 ", tag}, {31'd0, (r4 == 4'hF)}, 32'd0);
  endtask

  task automatic tick();
    @(posedge clk);
    m1 = model(m1, 32'h9, 4, 1);
    m2 = model(m2, 32'h9, 4, 2);
    m4 = model(m4, 32'h9, 4, 4);
    m8 = model(m8, 32'hB8, 8, 3);
    @(negedge clk);
    compare_all("run");
  endtask

  task automatic do_reset(input int hold);
    @(negedge clk);
    #1 rst_n = 0;
    #0.5;
    m1 = 0; m2 = 0; m4 = 0; m8 = 0;
    check("R1 async clear", {r1, r2, r4, r8}, 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R1 held", {r1, r2, r4, r8}, 32'd0);
    end
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int first_ret;
    void'($urandom(32'h5EED_0042));
    m1 = 0; m2 = 0; m4 = 0; m8 = 0;
    @(negedge clk);
    check("R1 power-up", {r1, r2, r4, r8}, 32'd0);
    @(negedge clk);
    rst_n = 1;

    tick();
    check("R3 first leap", {30'd0, r2}, 32'h0);
    tick();
    check("R3 second leap", {30'd0, r2}, 32'h2);

    do_reset(1);
    first_ret = 0;
    for (int c = 1; c <= 15; c++) begin
      tick();
      if (r4 == 4'h0 && first_ret == 0) first_ret = c;
    end
    check("R5 period", first_ret, 32'd15);

    for (int seg = 0; seg < 40; seg++) begin
      int len = $urandom_range(60, 3);
      for (int k = 0; k < len; k++) tick();
      do_reset($urandom_range(3, 0));
      tick();
      check("R6 restart", {30'd0, r2}, 32'h0);
      tick();
      check("R6 restart", {30'd0, r2}, 32'h2);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule